// File: doc/BRIEF.md
# Twin Sixteen-Bit Timer with Match Interrupts

This block is a memory-mapped timer with two independent 16-bit counters. Six match registers are shared between them. Each counter has its own value, prescale divider and control word. The control word picks run or halt, the count direction, and when the counter stops. A counter can stop at zero, stop on one chosen match register, or run freely and wrap around.

Only counter A feeds the interrupt logic. Each time counter A advances onto the value of a match register, the status bit for that register is set. A mask register decides which of the set status bits drive the interrupt line. Software clears status bits by writing ones to them.

One register slave serves two address windows, picked by two select inputs: a timer window and an interrupt window. The slave uses plain valid, write, address and data signals. Every write completes in the cycle it is presented. A read returns its data one cycle later, flagged by a one-cycle valid pulse. There is no back-pressure in either direction. The bus must present at most one access per cycle.

Top module: `twin_match_timer`

## Requirements
- R1: After reset the interrupt line is low and no read data is flagged. Each counter value reads 0, each divider reads 0 and each control word reads 0x10 (halted). Every match register, the mask and the status read 0.
- R2: The timer window is word addressed; address bits [1:0] are ignored. The registers sit at these offsets:
  - Counter A: value at 0x00, divider at 0x04, control at 0x08.
  - Counter B: value at 0x0C, divider at 0x10, control at 0x14.
  - Match register k (k = 0..5) at 0x18 + 4k.
  Values and match registers keep the low 16 bits of a write. Control keeps bits [4:0] and reads them back. A value write loads the counter directly and takes priority over any advance in that cycle.
- R3: The interrupt window has the status register at 0x00 (read; write ones to acknowledge) and the mask register at 0x04 (6 bits). In both, bit k belongs to match register k.
- R4: A read is accepted when `bus_valid` is high, `bus_write` is low and at least one select is high. The cycle after it, `rd_valid` is high for exactly one cycle with the data on `rd_data`. If both selects are high, the timer window is used. Offsets that hold no register read 0, and writes to them change nothing.
- R5: Control bit 4 set halts the counter, and its value holds.
- R6: Control bit 3 set makes the counter count up; cleared makes it count down. Mode 7 (control bits [2:0]) runs freely and wraps modulo 2^16 in both directions.
- R7: Mode 0 counts toward 0. Mode m in 1..6 counts toward match register m-1. A running counter in these modes advances only while its value differs from its target, so it stops and holds once the target is reached.
- R8: With divider D, a running counter advances once every D+1 clocks. The prescaler restarts on every control or divider write. The first advance comes D+1 clocks after the clock edge that takes the control write. The cycle that carries a control write never advances its counter.
- R9: Status bit k is set when counter A advances onto the value of match register k, whatever the mask holds. Advances of counter B and direct value loads never set status.
- R10: Writing a 1 to a status bit clears it. If a write of 1 to a status bit comes in the same cycle as a new match for that bit, the bit stays set.
- R11: `irq` is high exactly while some status bit and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| sel_tmr | input | 1 | Selects the timer window |
| sel_irq | input | 1 | Selects the interrupt window |
| bus_addr | input | 8 | Byte offset within the selected window |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Interrupt request, level |

## Verification
The status register can be hit by a match and an acknowledge write in the same cycle. To force this collision, counter A is loaded one below match register 1 and started free-running with no prescaling. The acknowledge for bit 1 is written on the very next bus cycle, which is exactly the edge at which the counter lands on the match. The bench then reads the status back and expects bit 1 still set. It then acknowledges again and expects the bit to clear. It also reads the counter and expects it to have stopped one above its load value, because the halting control write itself does not advance the counter.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  typedef struct packed {
    logic       halt;
    logic       up;
    logic [2:0] mode;
  } tmr_ctrl_t;

  localparam logic [2:0] MODE_TO_ZERO = 3'd0;
  localparam logic [2:0] MODE_FREE    = 3'd7;
  localparam int         CTRL_W       = $bits(tmr_ctrl_t);
  localparam tmr_ctrl_t  CTRL_RESET   = '{halt: 1'b1, up: 1'b0, mode: MODE_TO_ZERO};
endpackage

// File: rtl/tmt_prescaler.sv
module tmt_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] divide,
  output logic             tick
);
  logic [DIV_W-1:0] pcnt;

  assign tick = enable && (pcnt >= divide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt <= '0;
    else if (!enable)  pcnt <= '0;
    else if (tick)     pcnt <= '0;
    else               pcnt <= pcnt + 1'b1;
  end

  // a non-zero divider never yields ticks on two adjacent cycles
  assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divide != '0 && enable) |=> !tick);
endmodule

// File: rtl/tmt_channel.sv
module tmt_channel
  import tmt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DIV_W     = 16,
  parameter int NUM_MATCH = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_val,
  input  logic                       wr_div,
  input  logic                       wr_ctrl,
  input  logic [CNT_W-1:0]           wdata_cnt,
  input  logic [DIV_W-1:0]           wdata_div,
  input  tmr_ctrl_t                  wdata_ctrl,
  input  logic [NUM_MATCH*CNT_W-1:0] match_flat,
  output logic [CNT_W-1:0]           value,
  output logic [DIV_W-1:0]           divider,
  output tmr_ctrl_t                  ctrl,
  output logic                       step,
  output logic [CNT_W-1:0]           next_value
);
  logic             tick;
  logic [CNT_W-1:0] target;
  logic             at_target;

  tmt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (!ctrl.halt && !wr_ctrl && !wr_div),
    .divide (divider),
    .tick   (tick)
  );

  always_comb begin
    target    = '0;
    at_target = 1'b0;
    if (ctrl.mode != MODE_FREE) begin
      for (int k = 0; k < NUM_MATCH; k++)
        if (ctrl.mode == 3'(k + 1)) target = match_flat[k*CNT_W +: CNT_W];
      at_target = (value == target);
    end
  end

  assign next_value = ctrl.up ? value + 1'b1 : value - 1'b1;
  assign step       = tick && !at_target && !wr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value   <= '0;
      divider <= '0;
      ctrl    <= CTRL_RESET;
    end else begin
      if (wr_val)      value <= wdata_cnt;
      else if (step)   value <= next_value;
      if (wr_div)      divider <= wdata_div;
      if (wr_ctrl)     ctrl <= wdata_ctrl;
    end
  end

  assert_halt_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.halt && !wr_val) |=> $stable(value));

  assert_target_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode != MODE_FREE && value == target && !wr_val) |=> $stable(value));

  assert_unit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_val) |=> (value == $past(value)) || (value == $past(value) + CNT_W'(1))
                  || (value == $past(value) - CNT_W'(1)));
endmodule

// File: rtl/tmt_match_irq.sv
module tmt_match_irq #(
  parameter int CNT_W     = 16,
  parameter int NUM_MATCH = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step,
  input  logic [CNT_W-1:0]           next_value,
  input  logic [NUM_MATCH*CNT_W-1:0] match_flat,
  input  logic                       ack_wr,
  input  logic [NUM_MATCH-1:0]       ack_data,
  input  logic                       mask_wr,
  input  logic [NUM_MATCH-1:0]       mask_data,
  output logic [NUM_MATCH-1:0]       status,
  output logic [NUM_MATCH-1:0]       mask,
  output logic                       irq
);
  logic [NUM_MATCH-1:0] hit;

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_hit
    assign hit[k] = step && (next_value == match_flat[k*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= (status & ~(ack_wr ? ack_data : '0)) | hit;
      if (mask_wr) mask <= mask_data;
    end
  end

  assign irq = |(status & mask);

  assert_set_needs_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step) |=> ((status & ~$past(status)) == '0));

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !step) |=> ((status & $past(ack_data)) == '0));

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: rtl/twin_match_timer.sv
module twin_match_timer
  import tmt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DIV_W     = 16,
  parameter int NUM_MATCH = 6,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              sel_tmr,
  input  logic              sel_irq,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int WORD_W     = ADDR_W - 2;
  localparam int NUM_CH     = 2;
  localparam int CH_REGS    = 3;
  localparam int MATCH_BASE = NUM_CH * CH_REGS;
  localparam int IRQ_STAT   = 0;
  localparam int IRQ_MASK   = 1;

  logic [WORD_W-1:0] word;
  logic              wr_t, wr_i, rd_acc;
  logic              unused_bits;

  assign word        = bus_addr[ADDR_W-1:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};
  assign wr_t        = bus_valid && bus_write && sel_tmr;
  assign wr_i        = bus_valid && bus_write && sel_irq && !sel_tmr;
  assign rd_acc      = bus_valid && !bus_write && (sel_tmr || sel_irq);

  // shared match registers
  logic [CNT_W-1:0]           match_r [NUM_MATCH];
  logic [NUM_MATCH*CNT_W-1:0] match_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_MATCH; k++) match_r[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_MATCH; k++)
        if (wr_t && word == WORD_W'(MATCH_BASE + k)) match_r[k] <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb
    for (int k = 0; k < NUM_MATCH; k++) match_flat[k*CNT_W +: CNT_W] = match_r[k];

  // two counter channels
  logic [CNT_W-1:0] ch_val  [NUM_CH];
  logic [DIV_W-1:0] ch_div  [NUM_CH];
  tmr_ctrl_t        ch_ctrl [NUM_CH];
  logic [CNT_W-1:0] ch_next [NUM_CH];
  logic [NUM_CH-1:0] ch_step;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmt_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W), .NUM_MATCH(NUM_MATCH)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_val     (wr_t && word == WORD_W'(c*CH_REGS + 0)),
      .wr_div     (wr_t && word == WORD_W'(c*CH_REGS + 1)),
      .wr_ctrl    (wr_t && word == WORD_W'(c*CH_REGS + 2)),
      .wdata_cnt  (bus_wdata[CNT_W-1:0]),
      .wdata_div  (bus_wdata[DIV_W-1:0]),
      .wdata_ctrl (tmr_ctrl_t'(bus_wdata[CTRL_W-1:0])),
      .match_flat (match_flat),
      .value      (ch_val[c]),
      .divider    (ch_div[c]),
      .ctrl       (ch_ctrl[c]),
      .step       (ch_step[c]),
      .next_value (ch_next[c])
    );
  end

  // interrupt status from channel A only
  logic [NUM_MATCH-1:0] status, mask;

  tmt_match_irq #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (ch_step[0]),
    .next_value (ch_next[0]),
    .match_flat (match_flat),
    .ack_wr     (wr_i && word == WORD_W'(IRQ_STAT)),
    .ack_data   (bus_wdata[NUM_MATCH-1:0]),
    .mask_wr    (wr_i && word == WORD_W'(IRQ_MASK)),
    .mask_data  (bus_wdata[NUM_MATCH-1:0]),
    .status     (status),
    .mask       (mask),
    .irq        (irq)
  );

  // read path
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (sel_tmr) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (word == WORD_W'(c*CH_REGS + 0)) rd_next = DATA_W'(ch_val[c]);
        if (word == WORD_W'(c*CH_REGS + 1)) rd_next = DATA_W'(ch_div[c]);
        if (word == WORD_W'(c*CH_REGS + 2)) rd_next = DATA_W'(ch_ctrl[c]);
      end
      for (int k = 0; k < NUM_MATCH; k++)
        if (word == WORD_W'(MATCH_BASE + k)) rd_next = DATA_W'(match_r[k]);
    end else if (sel_irq) begin
      if (word == WORD_W'(IRQ_STAT)) rd_next = DATA_W'(status);
      if (word == WORD_W'(IRQ_MASK)) rd_next = DATA_W'(mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_acc;
      if (rd_acc) rd_data <= rd_next;
    end
  end

  assert_read_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rd_valid);

  assert_no_stray_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rd_valid);
endmodule

// File: tb/twin_match_timer_test.sv
module twin_match_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, sel_tmr = 1'b0, sel_irq = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid, irq;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;
  logic done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  twin_match_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .sel_tmr(sel_tmr), .sel_irq(sel_irq), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq));

  task automatic note(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one bus cycle, entered and left on a falling edge
  task automatic op(input bit w, input bit t, input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = w; sel_tmr = t; sel_irq = !t; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; sel_tmr = 1'b0; sel_irq = 1'b0;
  endtask

  task automatic wr_t(input logic [7:0] a, input logic [31:0] d); op(1'b1, 1'b1, a, d); endtask
  task automatic wr_i(input logic [7:0] a, input logic [31:0] d); op(1'b1, 1'b0, a, d); endtask

  task automatic rd(input bit t, input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    op(1'b0, t, a, 32'h0);
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk_irq(input bit exp, input string tag);
    note(irq == exp, tag, {31'b0, irq}, {31'b0, exp});
  endtask

  // monitor: pops the scoreboard whenever read data is flagged
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) note(1'b0, "R4 unexpected rd_valid", 32'h1, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string       s = tag_q.pop_front();
        note(rd_data === e, s, rd_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      note(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    note(rd_valid == 1'b0, "R1 rd_valid low", {31'b0, rd_valid}, 32'h0);
    chk_irq(1'b0, "R1 irq low");
    rd(1, 8'h00, 32'h0,  "R1 counter A value");
    rd(1, 8'h08, 32'h10, "R1 counter A control");
    rd(1, 8'h10, 32'h0,  "R1 counter B divider");
    rd(1, 8'h14, 32'h10, "R1 counter B control");
    rd(1, 8'h2C, 32'h0,  "R1 match 5");
    rd(0, 8'h00, 32'h0,  "R1 status");
    rd(0, 8'h04, 32'h0,  "R1 mask");

    // R2 map and readback widths
    wr_t(8'h04, 32'h0000ABCD);
    wr_t(8'h00, 32'h12345678);
    wr_t(8'h08, 32'hFFFFFFF0);
    rd(1, 8'h04, 32'hABCD, "R2 divider A readback");
    rd(1, 8'h00, 32'h5678, "R2 value keeps 16 bits");
    rd(1, 8'h08, 32'h10,   "R2 control keeps 5 bits");
    wr_t(8'h04, 32'h0);
    wr_t(8'h18, 32'h0000);
    wr_t(8'h1C, 32'h1001);
    wr_t(8'h20, 32'h0009);
    wr_t(8'h24, 32'h1003);
    wr_t(8'h28, 32'h1004);
    wr_t(8'h2C, 32'h1005);
    rd(1, 8'h20, 32'h9,    "R2 match 2 offset");
    rd(1, 8'h2C, 32'h1005, "R2 match 5 offset");

    // R4 undefined offsets
    wr_t(8'h30, 32'hFFFF);
    rd(1, 8'h30, 32'h0,    "R4 undefined timer offset");
    rd(0, 8'h08, 32'h0,    "R4 undefined irq offset");
    rd(1, 8'h2C, 32'h1005, "R4 undefined write ignored");

    // R7/R9 countdown on A to match 0 (=0), mask still 0
    wr_t(8'h00, 32'd5);
    wr_t(8'h08, 32'h01);
    idle(20);
    rd(1, 8'h00, 32'h0, "R7 A holds at match target");
    rd(0, 8'h00, 32'h01, "R9 status bit0 set unmasked");
    chk_irq(1'b0, "R11 irq low with mask clear");

    // R11 masking, R3 mask reg, R10 acknowledge
    wr_i(8'h04, 32'h01);
    chk_irq(1'b1, "R11 irq high when masked in");
    wr_i(8'h04, 32'h3E);
    chk_irq(1'b0, "R11 irq low with other bits masked");
    rd(0, 8'h04, 32'h3E, "R3 mask readback");
    wr_i(8'h00, 32'h01);
    rd(0, 8'h00, 32'h0, "R10 ack clears bit0");
    wr_i(8'h04, 32'h0);

    // R7 mode 0 on B; R9 B never sets status
    wr_t(8'h0C, 32'd3);
    wr_t(8'h14, 32'h00);
    idle(10);
    rd(1, 8'h0C, 32'h0, "R7 B stops at zero");
    rd(0, 8'h00, 32'h0, "R9 counter B sets no status");

    // R7 up count to match 2 on B
    wr_t(8'h0C, 32'd2);
    wr_t(8'h14, 32'h0B);
    idle(15);
    rd(1, 8'h0C, 32'h9, "R7 B counts up to match 2");

    // R5 halted holds
    wr_t(8'h14, 32'h1B);
    wr_t(8'h0C, 32'h55);
    idle(5);
    rd(1, 8'h0C, 32'h55, "R5 halted counter holds");

    // R6 forever up wrap: 3 advances, stop cycle does not advance
    wr_t(8'h00, 32'hFFFE);
    wr_t(8'h08, 32'h0F);
    idle(3);
    wr_t(8'h08, 32'h10);
    rd(1, 8'h00, 32'h0001, "R6 free-run up wraps");

    // R6 forever down wrap: 2 advances
    wr_t(8'h00, 32'h0001);
    wr_t(8'h08, 32'h07);
    idle(2);
    wr_t(8'h08, 32'h10);
    rd(1, 8'h00, 32'hFFFF, "R6 free-run down wraps");
    wr_i(8'h00, 32'h3F);
    rd(0, 8'h00, 32'h0, "R10 ack all clears");

    // R8 divider 3 on B: ticks at +4 and +8, the stop write at +12 does not advance
    wr_t(8'h10, 32'd3);
    wr_t(8'h0C, 32'd100);
    wr_t(8'h14, 32'h07);
    idle(11);
    wr_t(8'h14, 32'h17);
    rd(1, 8'h0C, 32'd98, "R8 divider paces B");

    // R10 collision: ack of bit1 in the cycle A lands on match 1
    wr_t(8'h1C, 32'h0201);
    wr_t(8'h00, 32'h0200);
    wr_t(8'h08, 32'h0F);
    wr_i(8'h00, 32'h02);
    wr_t(8'h08, 32'h10);
    rd(0, 8'h00, 32'h02, "R10 new match beats ack");
    rd(1, 8'h00, 32'h0201, "R8 control write cycle does not advance");
    wr_i(8'h00, 32'h02);
    rd(0, 8'h00, 32'h0, "R10 later ack clears");

    idle(4);
    note(exp_q.size() == 0, "R4 all reads answered", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule